// File: doc/BRIEF.md
# PLL Multiplier Control Sequencer

This block holds the control words for five clock-multiplier channels, numbered 1, 2, 3, 4 and 6, behind a small word-addressed register bus. Software stages an integer multiplier in a channel's primary word and sets the commit bit in the same write. The block then runs a lock-delay model: the commit bit stays set for a programmable number of cycles. When that count ends, the new multiplier becomes the active one, the commit bit clears, and the channel's settled flag rises in a shared status word. The settled flags sit at bit positions that depend on the channel number in a non-linear way.

No analog loop is modelled. Each channel instead reports its effective multiplication ratio as a number on an output port, together with flags for its fractional, dithering and centre-spread settings. A write that tries to change the multiplier while a change is still in flight is ignored, and a sticky per-channel error flag records it.

Word map (6-bit word address): 0x00 status, 0x01 error flags, 0x02 settle length, 0x10+s primary word of slot s, 0x18+s secondary word of slot s. Slots 0..4 hold channels 1, 2, 3, 4 and 6.

Top module: `pllseq_top`

## Requirements
- R1: After a synchronous reset, every register reads 0 except the settle length, which reads 64. Every ratio output is 2, and the frac, dither and centre outputs are 0.
- R2: The primary word layout is as follows. Bit 31 is the commit/busy bit. Bits 27:20 hold the multiplier field N. Bits 18:16 hold the mode field. Bits 14:8 hold the modulation rate and bits 6:0 the modulation depth. Bits 30:28, 19, 15 and 7 read 0. Written fields read back unchanged.
- R3: A slot's ratio output equals (N_active + 1) * 2. A primary write without bit 31 set leaves the ratio unchanged.
- R4: A primary write with bit 31 set, made while the slot is idle, keeps bit 31 reading 1 for L cycles, where L is the settle length. At the L-th clock edge after the write, bit 31 clears, the ratio takes the staged N, and the settled flag sets.
- R5: The settled flag of channel n is status bit 8+k, where k is n-1 for n<3, n for n=3 and n+1 for n>3. Channels 1, 2, 3, 4 and 6 therefore use bits 8, 9, 11, 13 and 15. All other status bits read 0.
- R6: Committing a change clears that channel's settled flag at the same clock edge.
- R7: A primary write while bit 31 is set leaves N unchanged and updates the mode, rate and depth fields. It also sets error bit s (for slot s) in the error word. That bit stays set until software writes a 1 to it at the error address.
- R8: frac_o is set when mode bit 18 is 1 or the secondary word is nonzero. dither_o follows mode bit 17 and center_o follows mode bit 16. Clearing the mode field and writing 0 to the secondary word turns off both fractional and dithering operation.
- R9: rdata shows the addressed word one clock edge after rd_en. Unmapped addresses read 0.
- R10: A settle length of 0 behaves as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ratio_o | output | 50 | Active ratio per slot, 10 bits each, slot s at [10s+9:10s] |
| frac_o | output | 5 | Fractional operation enabled per slot |
| dither_o | output | 5 | Dithering enabled per slot |
| center_o | output | 5 | Centre spread selected per slot |

## Verification
A stuck or mis-loaded settle counter shows up on a slot's ratio output at the expected completion edge. The ratio changes early, late or never, so the bench samples the ratio both one cycle before and at the L-th edge. A multiplier wrongly accepted during the busy window becomes visible in two ways: on the primary-word readback within the next read, and later in the committed ratio. A mis-mapped settled flag appears in the very first status read after a commit completes, because the bench checks the whole status word against its own bit map rather than one bit.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int NI_W    = 8;
  localparam int RATIO_W = NI_W + 2;

  localparam int A_STAT = 0;
  localparam int A_ERR  = 1;
  localparam int A_LEN  = 2;
  localparam int A_PRI  = 16;
  localparam int A_SEC  = 24;

  typedef struct packed {
    logic [NI_W-1:0] ni;
    logic [2:0]      mode;
    logic [6:0]      rate;
    logic [6:0]      depth;
  } ctrl_word_t;

  // Slot to channel number: slots 0..3 hold channels 1..4, later slots skip 5.
  function automatic int chan_num(input int slot);
    return (slot < 4) ? slot + 1 : slot + 2;
  endfunction

  // Status bit position of the settled flag of a slot.
  function automatic int settle_bit(input int slot);
    int n;
    int k;
    n = chan_num(slot);
    if (n < 3)      k = n - 1;
    else if (n > 3) k = n + 1;
    else            k = n;
    return 8 + k;
  endfunction
endpackage

// File: rtl/pllseq_settle.sv
module pllseq_settle #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= len;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  assert_busy_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0));
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_q);
endmodule

// File: rtl/pllseq_chan.sv
module pllseq_chan
  import pllseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_pri,
  input  logic               wr_sec,
  input  logic               err_clr,
  input  logic [31:0]        wdata,
  input  logic [CNT_W-1:0]   len_eff,
  output logic [31:0]        pri_rd,
  output logic [31:0]        sec_rd,
  output logic               settled_o,
  output logic               err_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               frac_o,
  output logic               dither_o,
  output logic               center_o
);
  ctrl_word_t         cw_q;
  logic [31:0]        sec_q;
  logic               settled_q;
  logic               err_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               busy;
  logic               done;
  logic               start;
  logic [RATIO_W-1:0] ni_plus;

  assign start   = wr_pri && !busy && wdata[31];
  assign ni_plus = RATIO_W'(cw_q.ni) + RATIO_W'(1);

  pllseq_settle #(.CNT_W(CNT_W)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .len    (len_eff),
    .busy_o (busy),
    .done_o (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q      <= '0;
      sec_q     <= '0;
      settled_q <= 1'b0;
      err_q     <= 1'b0;
      ratio_q   <= RATIO_W'(2);
    end else begin
      if (wr_sec) sec_q <= wdata;
      if (wr_pri) begin
        cw_q.mode  <= wdata[18:16];
        cw_q.rate  <= wdata[14:8];
        cw_q.depth <= wdata[6:0];
        if (!busy) cw_q.ni <= wdata[27:20];
      end
      if (wr_pri && busy) err_q <= 1'b1;
      else if (err_clr)   err_q <= 1'b0;
      if (done) begin
        settled_q <= 1'b1;
        ratio_q   <= {ni_plus[RATIO_W-2:0], 1'b0};
      end else if (start) begin
        settled_q <= 1'b0;
      end
    end
  end

  assign pri_rd    = {busy, 3'b000, cw_q.ni, 1'b0, cw_q.mode, 1'b0, cw_q.rate, 1'b0, cw_q.depth};
  assign sec_rd    = sec_q;
  assign settled_o = settled_q;
  assign err_o     = err_q;
  assign ratio_o   = ratio_q;
  assign frac_o    = cw_q.mode[2] | (|sec_q);
  assign dither_o  = cw_q.mode[1];
  assign center_o  = cw_q.mode[0];

  assert_ni_hold_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_pri) |=> (cw_q.ni == $past(cw_q.ni)));
  assert_err_on_busy_write_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_pri) |=> err_q);
  assert_settled_at_finish_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> settled_q);
  assert_commit_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !settled_q);
  assert_ratio_only_on_finish_R3: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(ratio_q));
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int NCH        = 5,
  parameter int CNT_W      = 16,
  parameter int DEF_SETTLE = 64,
  parameter int ADDR_W     = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [NCH*RATIO_W-1:0] ratio_o,
  output logic [NCH-1:0]         frac_o,
  output logic [NCH-1:0]         dither_o,
  output logic [NCH-1:0]         center_o
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_eff;
  logic [31:0]      pri_rd [NCH];
  logic [31:0]      sec_rd [NCH];
  logic [NCH-1:0]   settled;
  logic [NCH-1:0]   err;
  logic [31:0]      stat_w;
  logic [31:0]      rd_next;

  assign len_eff = (len_q == '0) ? CNT_W'(1) : len_q;

  always_ff @(posedge clk) begin
    if (rst)                                     len_q <= CNT_W'(DEF_SETTLE);
    else if (wr_en && addr == ADDR_W'(A_LEN))    len_q <= wdata[CNT_W-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pllseq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_pri    (wr_en && addr == ADDR_W'(A_PRI + g)),
      .wr_sec    (wr_en && addr == ADDR_W'(A_SEC + g)),
      .err_clr   (wr_en && addr == ADDR_W'(A_ERR) && wdata[g]),
      .wdata     (wdata),
      .len_eff   (len_eff),
      .pri_rd    (pri_rd[g]),
      .sec_rd    (sec_rd[g]),
      .settled_o (settled[g]),
      .err_o     (err[g]),
      .ratio_o   (ratio_o[g*RATIO_W +: RATIO_W]),
      .frac_o    (frac_o[g]),
      .dither_o  (dither_o[g]),
      .center_o  (center_o[g])
    );
  end

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < NCH; i++) stat_w[5'(settle_bit(i))] = settled[i];
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(A_STAT)) rd_next = stat_w;
    if (addr == ADDR_W'(A_ERR))  rd_next = 32'(err);
    if (addr == ADDR_W'(A_LEN))  rd_next = 32'(len_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(A_PRI + i)) rd_next = pri_rd[i];
      if (addr == ADDR_W'(A_SEC + i)) rd_next = sec_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && addr == ADDR_W'(A_ERR))) |=> ((err & $past(err)) == $past(err)));
endmodule

// File: tb/tb_pllseq_top.sv
module tb_pllseq_top;
  localparam int CLK_P = 10;
  localparam int NCH   = 5;
  localparam int RW    = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [5:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH*RW-1:0] ratio_o;
  logic [NCH-1:0]    frac_o;
  logic [NCH-1:0]    dither_o;
  logic [NCH-1:0]    center_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  pllseq_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ratio_o(ratio_o), .frac_o(frac_o),
    .dither_o(dither_o), .center_o(center_o)
  );

  // {slot[31:24], N[23:16], settle length[15:0]}
  localparam logic [31:0] VEC [6] = '{
    32'h0000_0003, 32'h01FF_0005, 32'h0263_0002,
    32'h0311_0001, 32'h047F_0040, 32'h0031_0000
  };

  function automatic int sbit(input int slot);
    case (slot)
      0: return 8;
      1: return 9;
      2: return 11;
      3: return 13;
      default: return 15;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  function automatic logic [31:0] rat(input int slot);
    return 32'(ratio_o[slot*RW +: RW]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    automatic logic [31:0] v;
    automatic logic [31:0] exp_stat = '0;
    automatic int exp_rat [NCH] = '{2, 2, 2, 2, 2};

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h00, v); chk("R1 status", v, 32'h0);
    rd(6'h01, v); chk("R1 error", v, 32'h0);
    rd(6'h02, v); chk("R1 length", v, 32'd64);
    rd(6'h10, v); chk("R1 primary", v, 32'h0);
    for (int s = 0; s < NCH; s++) chk("R1 ratio", rat(s), 32'd2);
    chk("R1 flags", 32'({frac_o, dither_o, center_o}), 32'h0);

    // Table walk: R3 R4 R5 R10
    for (int i = 0; i < 6; i++) begin
      automatic int s   = int'(VEC[i][31:24]);
      automatic int n   = int'(VEC[i][23:16]);
      automatic int l   = int'(VEC[i][15:0]);
      automatic int eff = (l == 0) ? 1 : l;
      wr(6'h02, 32'(l));
      wr(6'(16 + s), 32'h8000_0000 | (32'(n) << 20));
      repeat (eff - 1) @(negedge clk);
      chk("R4 ratio before settle", rat(s), 32'(exp_rat[s]));
      @(negedge clk);
      exp_rat[s] = (n + 1) * 2;
      chk((l == 0) ? "R10 zero length" : "R3 ratio at settle", rat(s), 32'(exp_rat[s]));
      exp_stat[sbit(s)] = 1'b1;
      rd(6'h00, v); chk("R5 status map", v, exp_stat);
      rd(6'(16 + s), v); chk("R4 commit cleared", v, 32'(n) << 20);
    end

    // R6 and R7: commit then write while busy
    wr(6'h02, 32'd10);
    wr(6'h11, 32'h8000_0000 | (32'd3 << 20));
    rd(6'h00, v); chk("R6 flag cleared", v, exp_stat & ~(32'h1 << 9));
    wr(6'h11, (32'd9 << 20) | 32'h11);
    rd(6'h11, v); chk("R7 N held, depth taken", v, 32'h8000_0000 | (32'd3 << 20) | 32'h11);
    rd(6'h01, v); chk("R7 error set", v, 32'h2);
    repeat (12) @(negedge clk);
    chk("R7 ratio uses held N", rat(1), 32'd8);
    rd(6'h00, v); chk("R6 flag back", v, exp_stat);
    rd(6'h01, v); chk("R7 error sticky", v, 32'h2);
    wr(6'h01, 32'h2);
    rd(6'h01, v); chk("R7 error cleared", v, 32'h0);

    // R2 layout, R3 no-commit write
    wr(6'h12, 32'h7FFF_FFFF);
    rd(6'h12, v); chk("R2 field layout", v, 32'h0FF7_7F7F);
    chk("R3 no commit keeps ratio", rat(2), 32'd200);
    chk("R8 all modes", 32'({frac_o[2], dither_o[2], center_o[2]}), 32'h7);

    // R8 secondary word
    wr(6'h12, 32'h0FF0_0000);
    wr(6'h1A, 32'd5);
    chk("R8 frac from secondary", 32'({frac_o[2], dither_o[2], center_o[2]}), 32'h4);
    rd(6'h1A, v); chk("R8 secondary readback", v, 32'd5);
    wr(6'h1A, 32'd0);
    chk("R8 all disabled", 32'({frac_o[2], dither_o[2], center_o[2]}), 32'h0);

    // R9 unmapped
    rd(6'h3F, v); chk("R9 unmapped", v, 32'h0);
    rd(6'h05, v); chk("R9 unmapped low", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule